// File: doc/BRIEF.md
# Dual-Execution Store Release Gate

This block holds every store produced by a leading thread until a second, redundant thread has produced the same store. Leading stores carry an address, a data word and a byte-enable mask. They enter an in-order buffer and never reach the data cache directly. The trailing thread presents its own copy of each store, in program order. That copy is compared field by field with the oldest buffered entry.

When the two copies agree, the buffered store goes out on a single cache write port, one store per cycle, under a valid/ready handshake. When they disagree, or when the trailing thread sends a store that has no buffered partner, no write is issued and a sticky error is raised. The block then stalls both threads until a recovery pulse flushes all held stores and clears the error. The trailing thread reaches the cache only through this port, so memory can change only after two independent executions have agreed.

Top module: `store_verify_buffer`

## Requirements
- R1: After reset, lead_ready is 1, cache_valid is 0, err_flag is 0 and fault_code is 0.
- R2: A store accepted from the leading thread never drives cache_valid on its own; cache_valid is 0 whenever no trailing store is presented.
- R3: When the trailing store equals the oldest buffered store in address, data and byte enables, cache_valid is 1 and cache_addr/cache_data/cache_be carry that store. Both copies are consumed when cache_ready is 1. Stores are released in the order the leading thread delivered them.
- R4: While a matching trailing store waits and cache_ready is 0, trail_ready stays 0 and the cache outputs hold the same store.
- R5: The buffer holds DEPTH stores (default 16). lead_ready is 0 while DEPTH stores are held, and a store offered then is not taken.
- R6: A trailing store that differs from the oldest entry in any one of address, data or byte enables is consumed. The oldest entry is discarded without a cache write, err_flag becomes 1 and fault_code becomes 1.
- R7: A trailing store presented while the buffer is empty is consumed without a cache write; err_flag becomes 1 and fault_code becomes 2.
- R8: While err_flag is 1, lead_ready, trail_ready and cache_valid are all 0.
- R9: While recover is 1, lead_ready and trail_ready are 0. In the cycle after recover, the buffer is empty, err_flag is 0 and fault_code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_valid | input | 1 | Leading thread offers a store |
| lead_ready | output | 1 | Buffer can take a leading store |
| lead_addr | input | 32 | Leading store address |
| lead_data | input | 64 | Leading store data |
| lead_be | input | 8 | Leading store byte enables |
| trail_valid | input | 1 | Trailing thread offers its copy of a store |
| trail_ready | output | 1 | Trailing copy is consumed this cycle |
| trail_addr | input | 32 | Trailing store address |
| trail_data | input | 64 | Trailing store data |
| trail_be | input | 8 | Trailing store byte enables |
| cache_valid | output | 1 | Verified store offered to the cache |
| cache_ready | input | 1 | Cache accepts the offered store |
| cache_addr | output | 32 | Verified store address |
| cache_data | output | 64 | Verified store data |
| cache_be | output | 8 | Verified store byte enables |
| recover | input | 1 | Flush all held stores and clear the error |
| err_flag | output | 1 | Sticky divergence error |
| fault_code | output | 2 | 0 none, 1 field mismatch, 2 trailing store with empty buffer |

## Verification
The release path is exercised with short runs of matching stores, with a run that fills the buffer to its limit and then drains it, and with a match held back by a stalled cache. Together these separate wrong ordering, lost entries and premature release. Divergence is injected in address, data and byte enables in turn, each with a second store queued behind it. This shows that each field is really compared and that the queued store is truly flushed by recovery rather than released. A trailing store sent to an empty buffer separates the orphan fault from the mismatch fault by its code.

// File: rtl/svb_pkg.sv
package svb_pkg;
    parameter int ADDR_W = 32;
    parameter int DATA_W = 64;
    localparam int BE_W = DATA_W / 8;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BE_W-1:0]   be;
    } store_t;

    typedef enum logic [1:0] {
        FAULT_NONE     = 2'd0,
        FAULT_MISMATCH = 2'd1,
        FAULT_ORPHAN   = 2'd2
    } fault_e;

    typedef enum logic [1:0] {
        VERDICT_IDLE,
        VERDICT_RELEASE,
        VERDICT_MISMATCH,
        VERDICT_ORPHAN
    } verdict_e;

    // One bit per field that differs: {addr, data, be}
    function automatic logic [2:0] field_diff(input store_t a, input store_t b);
        field_diff = {a.addr != b.addr, a.data != b.data, a.be != b.be};
    endfunction
endpackage

// File: rtl/svb_fifo.sv
module svb_fifo
    import svb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  store_t           push_item,
    input  logic             pop,
    output store_t           head,
    output logic             empty,
    output logic             full,
    output logic [CNT_W-1:0] occ
);
    store_t             slots [DEPTH];
    logic [DEPTH-1:0]   slot_we;
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        bump = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot_we
        assign slot_we[g] = push && (wr_ptr == PTR_W'(g));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (slot_we[i]) slots[i] <= push_item;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            occ    <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   occ <= occ + 1'b1;
                2'b01:   occ <= occ - 1'b1;
                default: occ <= occ;
            endcase
        end
    end

    assign head  = slots[rd_ptr];
    assign empty = (occ == '0);
    assign full  = (occ == CNT_W'(DEPTH));
endmodule

// File: rtl/svb_compare.sv
module svb_compare
    import svb_pkg::*;
(
    input  store_t   head,
    input  logic     head_present,
    input  logic     trail_valid,
    input  store_t   trail_item,
    input  logic     cache_ready,
    input  logic     halt,
    output logic     trail_ready,
    output logic     cache_valid,
    output verdict_e verdict
);
    logic agree;

    always_comb begin
        agree       = head_present && (field_diff(head, trail_item) == 3'b000);
        cache_valid = !halt && trail_valid && agree;
        // A disagreeing or orphan copy is absorbed at once; a match waits for the cache
        trail_ready = !halt && (!agree || cache_ready);
        verdict     = VERDICT_IDLE;
        if (trail_valid && trail_ready) begin
            if (!head_present) verdict = VERDICT_ORPHAN;
            else if (agree)    verdict = VERDICT_RELEASE;
            else               verdict = VERDICT_MISMATCH;
        end
    end
endmodule

// File: rtl/svb_fault.sv
module svb_fault
    import svb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     recover,
    input  verdict_e verdict,
    output logic     err_flag,
    output fault_e   fault
);
    always_ff @(posedge clk) begin
        if (rst || recover) begin
            err_flag <= 1'b0;
            fault    <= FAULT_NONE;
        end else if (!err_flag) begin
            case (verdict)
                VERDICT_MISMATCH: begin
                    err_flag <= 1'b1;
                    fault    <= FAULT_MISMATCH;
                end
                VERDICT_ORPHAN: begin
                    err_flag <= 1'b1;
                    fault    <= FAULT_ORPHAN;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/store_verify_buffer.sv
module store_verify_buffer
    import svb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lead_valid,
    output logic              lead_ready,
    input  logic [ADDR_W-1:0] lead_addr,
    input  logic [DATA_W-1:0] lead_data,
    input  logic [BE_W-1:0]   lead_be,
    input  logic              trail_valid,
    output logic              trail_ready,
    input  logic [ADDR_W-1:0] trail_addr,
    input  logic [DATA_W-1:0] trail_data,
    input  logic [BE_W-1:0]   trail_be,
    output logic              cache_valid,
    input  logic              cache_ready,
    output logic [ADDR_W-1:0] cache_addr,
    output logic [DATA_W-1:0] cache_data,
    output logic [BE_W-1:0]   cache_be,
    input  logic              recover,
    output logic              err_flag,
    output logic [1:0]        fault_code
);
    store_t           lead_item;
    store_t           trail_item;
    store_t           head;
    logic             empty;
    logic             full;
    logic [CNT_W-1:0] occ;
    logic             push;
    logic             pop;
    logic             halt;
    verdict_e         verdict;
    fault_e           fault;

    assign lead_item  = '{addr: lead_addr,  data: lead_data,  be: lead_be};
    assign trail_item = '{addr: trail_addr, data: trail_data, be: trail_be};

    assign halt       = err_flag || recover;
    assign lead_ready = !full && !halt;
    assign push       = lead_valid && lead_ready;
    assign pop        = (verdict == VERDICT_RELEASE) || (verdict == VERDICT_MISMATCH);

    svb_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .flush     (recover),
        .push      (push),
        .push_item (lead_item),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full),
        .occ       (occ)
    );

    svb_compare u_cmp (
        .head         (head),
        .head_present (!empty),
        .trail_valid  (trail_valid),
        .trail_item   (trail_item),
        .cache_ready  (cache_ready),
        .halt         (halt),
        .trail_ready  (trail_ready),
        .cache_valid  (cache_valid),
        .verdict      (verdict)
    );

    svb_fault u_fault (
        .clk      (clk),
        .rst      (rst),
        .recover  (recover),
        .verdict  (verdict),
        .err_flag (err_flag),
        .fault    (fault)
    );

    assign fault_code = fault;
    assign cache_addr = head.addr;
    assign cache_data = head.data;
    assign cache_be   = head.be;
endmodule

// File: rtl/svb_checker.sv
module svb_checker
    import svb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              lead_ready,
    input logic              trail_valid,
    input logic              trail_ready,
    input logic [ADDR_W-1:0] trail_addr,
    input logic [DATA_W-1:0] trail_data,
    input logic [BE_W-1:0]   trail_be,
    input logic              cache_valid,
    input logic              cache_ready,
    input logic [ADDR_W-1:0] cache_addr,
    input logic [DATA_W-1:0] cache_data,
    input logic [BE_W-1:0]   cache_be,
    input logic              recover,
    input logic              err_flag,
    input logic [1:0]        fault_code,
    input logic [CNT_W-1:0]  occ
);
    a_r5_occ_bound: assert property (@(posedge clk) disable iff (rst)
        occ <= CNT_W'(DEPTH));

    a_r5_full_blocks: assert property (@(posedge clk) disable iff (rst)
        (occ == CNT_W'(DEPTH)) |-> !lead_ready);

    a_r2_empty_no_release: assert property (@(posedge clk) disable iff (rst)
        (occ == '0) |-> !cache_valid);

    a_r3_release_matches_trail: assert property (@(posedge clk) disable iff (rst)
        cache_valid |-> (trail_valid && cache_addr == trail_addr
                         && cache_data == trail_data && cache_be == trail_be));

    a_r4_wait_for_cache: assert property (@(posedge clk) disable iff (rst)
        (cache_valid && !cache_ready) |-> !trail_ready);

    a_r6_reject_raises_error: assert property (@(posedge clk) disable iff (rst)
        (trail_valid && trail_ready && !cache_valid && !err_flag) |=> (err_flag && fault_code != 2'd0));

    a_r8_error_halts: assert property (@(posedge clk) disable iff (rst)
        err_flag |-> (!lead_ready && !trail_ready && !cache_valid));

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (rst)
        (err_flag && !recover) |=> err_flag);

    a_r9_recover_clears: assert property (@(posedge clk) disable iff (rst)
        recover |=> (!err_flag && fault_code == 2'd0 && occ == '0));
endmodule

bind store_verify_buffer svb_checker #(.DEPTH(DEPTH)) u_svb_checker (.*);

// File: tb/tb_store_verify_buffer.sv
module tb_store_verify_buffer;
    import svb_pkg::*;
    localparam int DEPTH = 16;

    logic              clk = 1'b0;
    logic              rst;
    logic              lead_valid;
    logic              lead_ready;
    logic [ADDR_W-1:0] lead_addr;
    logic [DATA_W-1:0] lead_data;
    logic [BE_W-1:0]   lead_be;
    logic              trail_valid;
    logic              trail_ready;
    logic [ADDR_W-1:0] trail_addr;
    logic [DATA_W-1:0] trail_data;
    logic [BE_W-1:0]   trail_be;
    logic              cache_valid;
    logic              cache_ready;
    logic [ADDR_W-1:0] cache_addr;
    logic [DATA_W-1:0] cache_data;
    logic [BE_W-1:0]   cache_be;
    logic              recover;
    logic              err_flag;
    logic [1:0]        fault_code;

    always #2 clk = ~clk;

    store_verify_buffer #(.DEPTH(DEPTH)) dut (.*);

    int     checks = 0;
    int     errors = 0;
    store_t expq[$];
    store_t got;
    store_t want;

    task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic store_t mk(input int i);
        store_t s;
        s.addr = 32'h0000_1000 + 32'(i) * 32'd8;
        s.data = {32'hA5A5_0000 + 32'(i), 32'(i) * 32'h0101_0101};
        s.be   = 8'hFF >> (i % 4);
        return s;
    endfunction

    task automatic lead_push(input store_t s);
        @(negedge clk);
        lead_valid = 1'b1;
        {lead_addr, lead_data, lead_be} = s;
        #1;
        while (!lead_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        lead_valid = 1'b0;
        expq.push_back(s);
    endtask

    task automatic trail_send(input store_t s);
        @(negedge clk);
        trail_valid = 1'b1;
        {trail_addr, trail_data, trail_be} = s;
        #1;
        while (!trail_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        trail_valid = 1'b0;
    endtask

    task automatic do_recover();
        @(negedge clk);
        recover = 1'b1;
        #1;
        chk(lead_ready == 1'b0, "R9 lead_ready during recover", 128'(lead_ready), 0);
        @(negedge clk);
        recover = 1'b0;
        #1;
        chk(err_flag == 1'b0, "R9 err_flag after recover", 128'(err_flag), 0);
        chk(fault_code == 2'd0, "R9 fault_code after recover", 128'(fault_code), 0);
        expq.delete();
    endtask

    // Scoreboard monitor: every cache handshake must match the oldest expected store (R3)
    always begin
        @(negedge clk); #2;
        if (!rst && cache_valid && cache_ready) begin
            got = {cache_addr, cache_data, cache_be};
            if (expq.size() == 0) begin
                chk(1'b0, "R2 cache write with nothing verified", 128'(got), 0);
            end else begin
                want = expq.pop_front();
                chk(got == want, "R3 released store contents/order", 128'(got), 128'(want));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        store_t a, b, bad, c;
        rst = 1'b1; lead_valid = 0; trail_valid = 0; recover = 0; cache_ready = 1'b1;
        lead_addr = '0; lead_data = '0; lead_be = '0;
        trail_addr = '0; trail_data = '0; trail_be = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk(lead_ready == 1'b1, "R1 lead_ready", 128'(lead_ready), 1);
        chk(cache_valid == 1'b0, "R1 cache_valid", 128'(cache_valid), 0);
        chk(err_flag == 1'b0, "R1 err_flag", 128'(err_flag), 0);
        chk(fault_code == 2'd0, "R1 fault_code", 128'(fault_code), 0);

        // R2 / R3: buffered stores wait, then release in order
        for (int i = 0; i < 3; i++) lead_push(mk(i));
        repeat (3) begin
            @(negedge clk); #1;
            chk(cache_valid == 1'b0, "R2 no release without trailing copy", 128'(cache_valid), 0);
        end
        for (int i = 0; i < 3; i++) trail_send(mk(i));
        @(negedge clk); #1;
        chk(expq.size() == 0, "R3 all three released", 128'(expq.size()), 0);

        // R4: stalled cache holds the match
        lead_push(mk(10));
        @(negedge clk);
        cache_ready = 1'b0;
        trail_valid = 1'b1;
        {trail_addr, trail_data, trail_be} = mk(10);
        repeat (3) begin
            @(negedge clk); #1;
            chk(trail_ready == 1'b0, "R4 trail_ready while cache stalled", 128'(trail_ready), 0);
            chk(cache_valid == 1'b1, "R4 cache_valid held", 128'(cache_valid), 1);
            chk(cache_addr == mk(10).addr, "R4 cache_addr held", 128'(cache_addr), 128'(mk(10).addr));
        end
        @(negedge clk);
        cache_ready = 1'b1;
        #1;
        chk(trail_ready == 1'b1, "R4 trail_ready once cache ready", 128'(trail_ready), 1);
        @(posedge clk); #1;
        trail_valid = 1'b0;
        @(negedge clk); #1;
        chk(expq.size() == 0, "R4 stalled store released", 128'(expq.size()), 0);

        // R5: fill to depth, extra store refused, then drain
        for (int i = 0; i < DEPTH; i++) lead_push(mk(20 + i));
        @(negedge clk);
        lead_valid = 1'b1;
        {lead_addr, lead_data, lead_be} = mk(99);
        repeat (2) begin
            #1;
            chk(lead_ready == 1'b0, "R5 lead_ready at full", 128'(lead_ready), 0);
            @(negedge clk);
        end
        lead_valid = 1'b0;
        for (int i = 0; i < DEPTH; i++) trail_send(mk(20 + i));
        @(negedge clk); #1;
        chk(expq.size() == 0, "R5 full buffer drained in order", 128'(expq.size()), 0);
        chk(lead_ready == 1'b1, "R5 lead_ready after drain", 128'(lead_ready), 1);

        // R7: trailing store with empty buffer (also proves the refused store was not taken)
        trail_send(mk(99));
        @(negedge clk); #1;
        chk(err_flag == 1'b1, "R7 err_flag on orphan", 128'(err_flag), 1);
        chk(fault_code == 2'd2, "R7 fault_code orphan", 128'(fault_code), 2);
        do_recover();

        // R6 / R8 / R9: divergence in each field in turn
        for (int f = 0; f < 3; f++) begin
            a = mk(40 + 2 * f);
            b = mk(41 + 2 * f);
            lead_push(a);
            lead_push(b);
            bad = a;
            if (f == 0) bad.addr = a.addr ^ 32'h4;
            if (f == 1) bad.data = a.data ^ 64'h1;
            if (f == 2) bad.be   = a.be ^ 8'h80;
            trail_send(bad);
            void'(expq.pop_front());
            @(negedge clk); #1;
            chk(err_flag == 1'b1, "R6 err_flag on mismatch", 128'(err_flag), 1);
            chk(fault_code == 2'd1, "R6 fault_code mismatch", 128'(fault_code), 1);
            @(negedge clk);
            trail_valid = 1'b1;
            {trail_addr, trail_data, trail_be} = b;
            lead_valid = 1'b1;
            {lead_addr, lead_data, lead_be} = mk(90);
            repeat (2) begin
                #1;
                chk(trail_ready == 1'b0, "R8 trail_ready while in error", 128'(trail_ready), 0);
                chk(lead_ready == 1'b0, "R8 lead_ready while in error", 128'(lead_ready), 0);
                chk(cache_valid == 1'b0, "R8 cache_valid while in error", 128'(cache_valid), 0);
                @(negedge clk);
            end
            trail_valid = 1'b0;
            lead_valid = 1'b0;
            do_recover();
            c = mk(60 + f);
            lead_push(c);
            trail_send(c);
            @(negedge clk); #1;
            chk(err_flag == 1'b0, "R9 flushed buffer accepts fresh store", 128'(err_flag), 0);
            chk(expq.size() == 0, "R9 fresh store released", 128'(expq.size()), 0);
        end

        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule